// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a memory-mapped watchdog timer. A 16-bit up-counter advances once per prescaled tick. When the counter wraps past 0xFFFF while the timer is enabled, the block raises a fixed-length reset pulse. It also sets an overflow flag that stays set after that reset, so software can later find out why the system restarted.

Every write carries a key in its upper bits, and the key is different for the counter and for the control registers. A write with the wrong key changes nothing. A write to the counter does not land at once. It passes through a short transfer window, during which a busy flag reads 1, so software polls that flag before it sets the enable bit.

To program a timeout of N ticks, software loads 65536 minus N. Software can read the counter at any time and compute the remaining time as 65536 minus the value read.

Top module: `key_wdt`

## Requirements
- R1: A write to byte offset 0 whose bits 31:16 equal 0x5A5A loads bits 15:0 into the counter. While enabled, the counter counts up by one per prescaler tick, and a read of offset 0 returns it in bits 15:0 at any time.
- R2: A write whose key is wrong (offset 0 needs 0x5A5A in bits 31:16; offsets 4 and 8 need 0xA5A5A5 in bits 31:8) leaves the counter, all control state and the overflow flag unchanged.
- R3: Control A bits 2:0 select the prescaler ratio: 0→1, 1→4, 2→16, 3→32, 4→64, 5→128, 6→1024, 7→4096. After enabling from a cleared prescaler, the first tick comes after exactly that many cycles.
- R4: Control A bit 7 is the enable. While it is 0, the counter holds its value and the prescaler is held at zero.
- R5: A tick that finds the counter at 0xFFFF while enabled wraps the counter to 0 and sets the overflow flag (control A bit 4).
- R6: The overflow flag stays set until a keyed control A write with bit 4 = 0 clears it. A keyed write with bit 4 = 1 leaves the flag unchanged, and only power-on reset clears it otherwise.
- R7: After an accepted counter write, the busy flag (control A bit 5) reads 1 for 3 cycles, and the new value appears in the counter as the flag clears. A counter write that arrives while busy is ignored.
- R8: On overflow, wdt_rst_o is high for exactly 16 cycles, starting the cycle after the wrapping edge.
- R9: Reads: offset 0 returns {16'h0, counter}; offset 4 returns {24'h0, enable, 0, busy, overflow, 0, ratio[2:0]}; offset 8 returns the last keyed 8-bit control B payload; any other offset returns 0. All fields read 0 after power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte address of the register |
| wdata_i | input | 32 | Write data, key in the upper bits |
| rdata_o | output | 32 | Combinational read data for addr_i |
| wdt_rst_o | output | 1 | Reset pulse raised on overflow |

## Verification
The counting path is tried under every divide ratio, each time from a zero count and a freshly cleared prescaler. Reading the count one cycle before and on the second tick separates ratio decoding from an off-by-one in the prescaler. Keyed and wrongly-keyed writes go to each register, and each is followed by readback, which tells a rejected write apart from one that only failed to read back. A load near 0xFFFF exercises the wrap, the overflow flag, the pulse length and the clearing rules of the sticky flag. A behavioural model tracks the read data and the reset output on every cycle throughout.

// File: rtl/key_wdt_pkg.sv
package key_wdt_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CTLA = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_CTLB = 4'h8;
  localparam logic [15:0] KEY_CNT = 16'h5A5A;
  localparam logic [23:0] KEY_CTL = 24'hA5A5A5;

  // ratio minus one, so the prescaler compares directly
  function automatic logic [11:0] div_limit(input logic [2:0] sel);
    case (sel)
      3'd0: div_limit = 12'd0;
      3'd1: div_limit = 12'd3;
      3'd2: div_limit = 12'd15;
      3'd3: div_limit = 12'd31;
      3'd4: div_limit = 12'd63;
      3'd5: div_limit = 12'd127;
      3'd6: div_limit = 12'd1023;
      default: div_limit = 12'd4095;
    endcase
  endfunction
endpackage

// File: rtl/key_wdt_regs.sv
module key_wdt_regs
  import key_wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ovf_set_i,
  input  logic              busy_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              en_o,
  output logic [2:0]        cks_o,
  output logic              ovf_o,
  output logic              cnt_wr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic       acc_a, acc_b;
  logic [7:0] ctlb_q;

  assign cnt_wr_o = we_i && addr_i == OFS_CNT  && wdata_i[31:16] == KEY_CNT;
  assign acc_a    = we_i && addr_i == OFS_CTLA && wdata_i[31:8]  == KEY_CTL;
  assign acc_b    = we_i && addr_i == OFS_CTLB && wdata_i[31:8]  == KEY_CTL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      cks_o  <= '0;
      ovf_o  <= 1'b0;
      ctlb_q <= '0;
    end else begin
      if (acc_a) begin
        en_o  <= wdata_i[7];
        cks_o <= wdata_i[2:0];
      end
      if (acc_b) ctlb_q <= wdata_i[7:0];
      if (ovf_set_i) ovf_o <= 1'b1;
      else if (acc_a && !wdata_i[4]) ovf_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_CNT:  rdata_o[CNT_W-1:0] = cnt_i;
      OFS_CTLA: rdata_o[7:0] = {en_o, 1'b0, busy_i, ovf_o, 1'b0, cks_o};
      OFS_CTLB: rdata_o[7:0] = ctlb_q;
      default:  rdata_o = '0;
    endcase
  end

  // R2
  bad_key_ctl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_CTLA && wdata_i[31:8] != KEY_CTL)
      |=> ($stable(en_o) && $stable(cks_o)));
  // R6
  ovf_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovf_o) |-> $past(we_i && addr_i == OFS_CTLA
                           && wdata_i[31:8] == KEY_CTL && !wdata_i[4]));
  // R6
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_set_i |=> ovf_o);
endmodule

// File: rtl/key_wdt_prescaler.sv
module key_wdt_prescaler
  import key_wdt_pkg::*;
#(
  parameter int unsigned PSC_W = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [2:0] cks_i,
  output logic       tick_o
);
  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] lim;

  assign lim    = PSC_W'(div_limit(cks_i));
  // >= so a ratio change mid-count cannot strand the prescaler
  assign tick_o = en_i && psc_q >= lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     psc_q <= '0;
    else if (!en_i)  psc_q <= '0;
    else if (tick_o) psc_q <= '0;
    else             psc_q <= psc_q + 1'b1;
  end
endmodule

// File: rtl/key_wdt_counter.sv
module key_wdt_counter #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_CYCLES = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o,
  output logic             ovf_evt_o
);
  localparam int unsigned BW = $clog2(SYNC_CYCLES + 1);

  logic [BW-1:0]    busy_q;
  logic [CNT_W-1:0] pend_q;
  logic             load;

  assign busy_o    = busy_q != '0;
  assign load      = busy_q == BW'(1);
  assign ovf_evt_o = tick_i && !load && (&cnt_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
      pend_q <= '0;
      cnt_o  <= '0;
    end else begin
      if (busy_o) busy_q <= busy_q - 1'b1;
      if (wr_i && !busy_o) begin
        pend_q <= wdata_i;
        busy_q <= BW'(SYNC_CYCLES);
      end
      if (load)        cnt_o <= pend_q;
      else if (tick_i) cnt_o <= cnt_o + 1'b1;
    end
  end

  // R7
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_i));
  // R7
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o);
  // R5
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_o |=> cnt_o == '0);
endmodule

// File: rtl/key_wdt_rstgen.sv
module key_wdt_rstgen #(
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_evt_i,
  output logic rst_o
);
  localparam int unsigned RW = $clog2(RST_CYCLES + 1);

  logic [RW-1:0] left_q;

  assign rst_o = left_q != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        left_q <= '0;
    else if (ovf_evt_i) left_q <= RW'(RST_CYCLES);
    else if (rst_o)     left_q <= left_q - 1'b1;
  end

  // R8
  rst_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_i |=> rst_o);
  // R8
  rst_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_o) |-> $past(ovf_evt_i));
endmodule

// File: rtl/key_wdt.sv
module key_wdt
  import key_wdt_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PSC_W       = 12,
  parameter int unsigned SYNC_CYCLES = 3,
  parameter int unsigned RST_CYCLES  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wdt_rst_o
);
  logic             en, ovf, cnt_wr, tick, busy, ovf_evt;
  logic [2:0]       cks;
  logic [CNT_W-1:0] cnt;

  key_wdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .ovf_set_i(ovf_evt), .busy_i(busy), .cnt_i(cnt),
    .en_o(en), .cks_o(cks), .ovf_o(ovf), .cnt_wr_o(cnt_wr), .rdata_o
  );

  key_wdt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i, .rst_ni, .en_i(en), .cks_i(cks), .tick_o(tick)
  );

  key_wdt_counter #(.CNT_W(CNT_W), .SYNC_CYCLES(SYNC_CYCLES)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .wr_i(cnt_wr),
    .wdata_i(wdata_i[CNT_W-1:0]),
    .cnt_o(cnt), .busy_o(busy), .ovf_evt_o(ovf_evt)
  );

  key_wdt_rstgen #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk_i, .rst_ni, .ovf_evt_i(ovf_evt), .rst_o(wdt_rst_o)
  );

  // R4
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !busy) |=> $stable(cnt));
  // R5
  ovf_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf) |-> $past(en));
endmodule

// File: tb/tb_key_wdt.sv
module tb_key_wdt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wdt_rst;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  key_wdt dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .wdt_rst_o(wdt_rst)
  );

  // behavioural reference
  int m_cnt, m_pend, m_busy, m_psc, m_cks, m_rstc;
  bit m_en, m_ovf;
  int m_ctlb;

  function automatic int ratio(input int k);
    case (k)
      0: return 1;     1: return 4;    2: return 16;   3: return 32;
      4: return 64;    5: return 128;  6: return 1024; default: return 4096;
    endcase
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'h0: return 32'(m_cnt);
      4'h4: return {24'h0, m_en, 1'b0, m_busy > 0, m_ovf, 1'b0, 3'(m_cks)};
      4'h8: return 32'(m_ctlb);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pend = 0; m_busy = 0; m_psc = 0; m_cks = 0;
      m_rstc = 0; m_en = 0; m_ovf = 0; m_ctlb = 0;
    end else begin
      bit tick, ld, evt;
      int nb;
      tick = m_en && (m_psc >= ratio(m_cks) - 1);
      ld = (m_busy == 1);
      evt = 0;
      nb = (m_busy > 0) ? m_busy - 1 : 0;
      if (ld) m_cnt = m_pend;
      else if (tick) begin
        if (m_cnt == 65535) begin m_cnt = 0; evt = 1; end
        else m_cnt = m_cnt + 1;
      end
      m_psc = !m_en ? 0 : (tick ? 0 : m_psc + 1);
      if (we && addr == 4'h0 && wdata[31:16] == 16'h5A5A && m_busy == 0) begin
        m_pend = int'(wdata[15:0]);
        nb = 3;
      end
      m_busy = nb;
      if (evt) m_ovf = 1;
      else if (we && addr == 4'h4 && wdata[31:8] == 24'hA5A5A5 && !wdata[4]) m_ovf = 0;
      if (we && addr == 4'h4 && wdata[31:8] == 24'hA5A5A5) begin
        m_en = wdata[7];
        m_cks = int'(wdata[2:0]);
      end
      if (we && addr == 4'h8 && wdata[31:8] == 24'hA5A5A5) m_ctlb = int'(wdata[7:0]);
      if (evt) m_rstc = 16;
      else if (m_rstc > 0) m_rstc = m_rstc - 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(rdata == m_read(addr), "R9 model rdata", rdata, m_read(addr));
      check(wdt_rst == (m_rstc > 0), "R8 model rst", 32'(wdt_rst), 32'(m_rstc > 0));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1;
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int n;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R9 reset state
    rd(4'h4, v); check(v == 0, "R9 reset ctlA", v, 0);
    rd(4'h0, v); check(v == 0, "R9 reset cnt", v, 0);
    check(wdt_rst == 0, "R8 reset rst", 32'(wdt_rst), 0);

    // R2 wrong keys
    wr(4'h4, 32'hA5A5A485);
    rd(4'h4, v); check(v == 0, "R2 bad ctlA key", v, 0);
    wr(4'h0, 32'h5A5B1234);
    idle(5);
    rd(4'h0, v); check(v == 0, "R2 bad cnt key", v, 0);
    wr(4'h8, 32'h00000033);
    rd(4'h8, v); check(v == 0, "R2 bad ctlB key", v, 0);

    // R9 control B and unused offset
    wr(4'h8, 32'hA5A5A5C3);
    rd(4'h8, v); check(v == 32'hC3, "R9 ctlB readback", v, 32'hC3);
    rd(4'hC, v); check(v == 0, "R9 unused offset", v, 0);

    // R7 busy window, second write ignored; R1 load
    wr(4'h0, 32'h5A5A1234);
    rd(4'h4, v); check(v[5] == 1'b1, "R7 busy set", v, 32'h20);
    wr(4'h0, 32'h5A5A9999);
    idle(3);
    rd(4'h4, v); check(v[5] == 1'b0, "R7 busy clear", v, 0);
    rd(4'h0, v); check(v == 32'h1234, "R7 write while busy ignored", v, 32'h1234);
    check(v == 32'h1234, "R1 keyed load", v, 32'h1234);

    // R4 hold while disabled
    idle(20);
    rd(4'h0, v); check(v == 32'h1234, "R4 hold when off", v, 32'h1234);

    // R3 each ratio
    for (int k = 0; k < 8; k++) begin
      int d;
      d = ratio(k);
      wr(4'h4, 32'hA5A5A500 | k);
      wr(4'h0, 32'h5A5A0000);
      idle(4);
      wr(4'h4, 32'hA5A5A580 | k);
      idle(2 * d - 1);
      rd(4'h0, v); check(v == 1, $sformatf("R3 ratio %0d first", d), v, 1);
      idle(1);
      rd(4'h0, v); check(v == 2, $sformatf("R3 ratio %0d second", d), v, 2);
    end

    // R5 / R8 overflow
    wr(4'h4, 32'hA5A5A500);
    wr(4'h0, 32'h5A5AFFF0);
    idle(4);
    wr(4'h4, 32'hA5A5A580);
    n = 0;
    while (!wdt_rst && n < 100) begin idle(1); n++; end
    rd(4'h0, v); check(v == 0, "R5 wrap to zero", v, 0);
    rd(4'h4, v); check(v == 32'h90, "R5 overflow flag", v, 32'h90);
    n = 1;
    for (int i = 0; i < 40; i++) begin
      idle(1);
      if (wdt_rst) n++;
    end
    check(n == 16, "R8 pulse length", n, 16);

    // R6 sticky flag
    wr(4'h4, 32'hA5A5A590);
    rd(4'h4, v); check(v[4] == 1'b1, "R6 bit4=1 keeps flag", v, 32'h90);
    wr(4'h4, 32'hA5A5A400);
    rd(4'h4, v); check(v[4] == 1'b1 && v[7], "R2 bad key keeps flag", v, 32'h90);
    wr(4'h4, 32'hA5A5A580);
    rd(4'h4, v); check(v == 32'h80, "R6 keyed clear", v, 32'h80);

    // R1 counting read
    rd(4'h0, v);
    idle(5);
    rd(4'h0, v2); check(v2 == v + 5, "R1 counts up", v2, v + 5);

    idle(10);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule